// File: doc/BRIEF.md
# Main/Auxiliary Memory Copy Engine

This block copies data between a main memory and an auxiliary audio memory in either direction. Software loads a main-memory address, an auxiliary address and a byte count through a small 16-bit register port. The top bit of the count's upper half picks the direction. Writing the lower half of the count starts the copy. The engine then moves one 64-bit word (8 bytes) per beat through two simple memory ports. Both addresses advance by 8 and the count drops by 8 on each beat.

Completion is tied to a fixed cost rather than to the beats themselves. The engine stays busy for 246 cycles per 32-byte block. When busy falls, it sets an interrupt flag, which software clears by writing 1 to it.

One memory-map setting doubles every main-to-auxiliary write that lands in the lowest 4 MB, so the same data also appears 4 MB higher. A beat whose auxiliary address is outside the fitted auxiliary size touches neither memory, but it still advances the addresses and the count.

Top module: `auxmem_dma`

## Requirements
- R1: Register offsets and write masks are as follows. Offset 0 is main address bits [25:16] (mask 0x03FF). Offset 1 is main address bits [15:0] (mask 0xFFE0). Offset 2 is auxiliary address bits [25:16] (mask 0x03FF). Offset 3 is auxiliary address bits [15:0] (mask 0xFFE0). Offset 4 is count bits [25:16] (mask 0x03FF) plus the direction in bit 15. Offset 5 is count bits [15:0] (mask 0xFFE0). Offset 6 is the map setting (mask 0x007F). Each offset reads back its masked value.
- R2: Offset 7 is a mode register. It always reads 0x0001, and writes to it have no effect.
- R3: A write to offset 5 while idle starts a transfer. Status (offset 8) bit 0, busy, reads 1 from the next cycle.
- R4: Direction 0 copies main to auxiliary, and direction 1 copies auxiliary to main. Each beat moves the 64-bit word at source offset k to destination offset k, for k = 0, 8, … up to count−8.
- R5: Addresses are 26 bits wide and wrap modulo 64 MB during a transfer. After completion, the address registers read start + count (mod 2^26), and the count reads 0.
- R6: Busy stays high for exactly (count/32)·246 + 1 cycles. On the edge where busy falls, status bit 1 (the interrupt flag) and the `irq` output become 1.
- R7: Writing status with bit 1 set clears the interrupt flag.
- R8: Doubling applies when map bits [3:0] equal 4 and the direction is main-to-auxiliary. In that case, a beat whose auxiliary address is below 0x400000 is also written at that address + 0x400000, as long as that address is in range. No other setting or direction produces an extra write.
- R9: A beat whose auxiliary address is at or above AUX_SIZE makes no read and no write on either memory port. The transfer still completes with the timing of R6.
- R10: While busy, writes to offsets 0–5 are ignored, including a second start. The running transfer keeps its count, timing and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt flag |
| mm_addr | output | 26 | Main memory byte address |
| mm_rd | output | 1 | Main memory read enable |
| mm_wr | output | 1 | Main memory write enable |
| mm_wdata | output | 64 | Main memory write data |
| mm_rdata | input | 64 | Main memory read data, valid in the same cycle |
| ax_addr | output | 26 | Auxiliary memory byte address |
| ax_rd | output | 1 | Auxiliary memory read enable |
| ax_wr | output | 1 | Auxiliary memory write enable |
| ax_wdata | output | 64 | Auxiliary memory write data |
| ax_rdata | input | 64 | Auxiliary memory read data, valid in the same cycle |

## Verification
The copy is tried with random lengths of one to four blocks, both directions, and map settings 0, 3 and 4. Random main and auxiliary addresses are drawn from low memory, from the band straddling the 4 MB doubling limit, and from the band straddling the auxiliary size limit. These patterns separate a correct direction decode from a swapped one. They also show that doubling is tied to both the setting and the address, and that out-of-range beats are skipped rather than stopping the transfer. Directed cases cover a main address that wraps past the 64 MB boundary, a zero count, and a restart attempted mid-transfer.

// File: rtl/auxmem_dma.sv
module auxmem_dma #(
  parameter logic [26:0] AUX_SIZE   = 27'h1000000,
  parameter int          BLOCK_COST = 246
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic [25:0] mm_addr,
  output logic        mm_rd,
  output logic        mm_wr,
  output logic [63:0] mm_wdata,
  input  logic [63:0] mm_rdata,
  output logic [25:0] ax_addr,
  output logic        ax_rd,
  output logic        ax_wr,
  output logic [63:0] ax_wdata,
  input  logic [63:0] ax_rdata
);
  localparam logic [25:0] DUP_SPAN = 26'h0400000;
  localparam logic [15:0] LO_MASK  = 16'hFFE0;

  logic [25:0] mm_a, ax_a, cnt;
  logic        dir, busy, irq_q, dup_ph;
  logic [6:0]  info;
  logic [31:0] tmr;
  logic [63:0] dbuf;

  logic in_rng, dup_ok, beat, step, finish, xfer_wr;

  assign in_rng = {1'b0, ax_a} < AUX_SIZE;
  assign dup_ok = (info[3:0] == 4'd4) && !dir && (ax_a < DUP_SPAN) &&
                  (({1'b0, ax_a} + {1'b0, DUP_SPAN}) < AUX_SIZE);
  assign beat   = busy && !dup_ph && (cnt != 26'd0);
  assign step   = (beat && !(in_rng && dup_ok)) || dup_ph;
  assign finish = busy && !dup_ph && (cnt == 26'd0) && (tmr == 32'd0);
  assign xfer_wr = reg_we && !busy;

  assign mm_addr  = mm_a;
  assign ax_addr  = dup_ph ? ax_a + DUP_SPAN : ax_a;
  assign mm_rd    = beat && in_rng && !dir;
  assign ax_rd    = beat && in_rng && dir;
  assign mm_wr    = ax_rd;
  assign ax_wr    = mm_rd || dup_ph;
  assign mm_wdata = ax_rdata;
  assign ax_wdata = dup_ph ? dbuf : mm_rdata;
  assign irq      = irq_q;

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = {6'd0, mm_a[25:16]};
      4'd1:    reg_rdata = mm_a[15:0];
      4'd2:    reg_rdata = {6'd0, ax_a[25:16]};
      4'd3:    reg_rdata = ax_a[15:0];
      4'd4:    reg_rdata = {dir, 5'd0, cnt[25:16]};
      4'd5:    reg_rdata = cnt[15:0];
      4'd6:    reg_rdata = {9'd0, info};
      4'd7:    reg_rdata = 16'h0001;
      4'd8:    reg_rdata = {14'd0, irq_q, busy};
      default: reg_rdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm_a <= '0; ax_a <= '0; cnt <= '0; dir <= 1'b0; info <= '0;
      busy <= 1'b0; irq_q <= 1'b0; dup_ph <= 1'b0; tmr <= '0; dbuf <= '0;
    end else begin
      if (xfer_wr) begin
        case (reg_addr)
          4'd0: mm_a[25:16] <= reg_wdata[9:0];
          4'd1: mm_a[15:0]  <= reg_wdata & LO_MASK;
          4'd2: ax_a[25:16] <= reg_wdata[9:0];
          4'd3: ax_a[15:0]  <= reg_wdata & LO_MASK;
          4'd4: begin cnt[25:16] <= reg_wdata[9:0]; dir <= reg_wdata[15]; end
          4'd5: begin
            cnt[15:0] <= reg_wdata & LO_MASK;
            busy      <= 1'b1;
            tmr       <= 32'({cnt[25:16], reg_wdata[15:5]}) * 32'(BLOCK_COST);
          end
          default: ;
        endcase
      end
      if (reg_we && reg_addr == 4'd6) info <= reg_wdata[6:0];
      if (reg_we && reg_addr == 4'd8 && reg_wdata[1]) irq_q <= 1'b0;

      if (busy && tmr != 32'd0) tmr <= tmr - 32'd1;
      if (beat && in_rng && dup_ok) begin
        dup_ph <= 1'b1;
        dbuf   <= mm_rdata;
      end
      if (dup_ph) dup_ph <= 1'b0;
      if (step) begin
        mm_a <= mm_a + 26'd8;
        ax_a <= ax_a + 26'd8;
        cnt  <= cnt - 26'd8;
      end
      if (finish) begin
        busy  <= 1'b0;
        irq_q <= 1'b1;
      end
    end
  end
endmodule

module auxmem_dma_chk #(
  parameter logic [26:0] AUX_SIZE = 27'h1000000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        irq,
  input logic        dir,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic [15:0] reg_rdata,
  input logic        ax_rd,
  input logic        ax_wr,
  input logic [25:0] ax_addr,
  input logic        mm_rd,
  input logic        mm_wr
);
  // R2
  mode_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 4'd7 |-> reg_rdata == 16'h0001);
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 4'd5 && !busy |=> busy);
  // R6
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
  // R9
  aux_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ax_rd || ax_wr) |-> ({1'b0, ax_addr} < AUX_SIZE));
  // R4
  one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_wr && ax_wr) && !(mm_rd && ax_rd));
  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && reg_addr == 4'd4 |=> $stable(dir));
endmodule

bind auxmem_dma auxmem_dma_chk #(.AUX_SIZE(AUX_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .dir(dir),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .ax_rd(ax_rd), .ax_wr(ax_wr), .ax_addr(ax_addr),
  .mm_rd(mm_rd), .mm_wr(mm_wr)
);

// File: tb/auxmem_dma_bench.sv
`timescale 1ns/1ps
module auxmem_dma_bench;
  localparam logic [26:0] AUX_SIZE = 27'h0800000;
  localparam int COST = 246;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0, reg_rdata;
  logic irq, mm_rd, mm_wr, ax_rd, ax_wr;
  logic [25:0] mm_addr, ax_addr;
  logic [63:0] mm_wdata, mm_rdata, ax_wdata, ax_rdata;

  logic [63:0] mmem [64];
  logic [63:0] amem [128];
  logic [63:0] emm  [64];
  logic [63:0] eam  [128];

  int compared = 0, mismatched = 0, acc = 0, cyc = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  auxmem_dma #(.AUX_SIZE(AUX_SIZE), .BLOCK_COST(COST)) u_auxmem_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mm_addr(mm_addr), .mm_rd(mm_rd), .mm_wr(mm_wr), .mm_wdata(mm_wdata),
    .mm_rdata(mm_rdata), .ax_addr(ax_addr), .ax_rd(ax_rd), .ax_wr(ax_wr),
    .ax_wdata(ax_wdata), .ax_rdata(ax_rdata));

  function automatic int mi(logic [25:0] a); return int'(a[8:3]); endfunction
  function automatic int ai(logic [25:0] a); return int'({a[22], a[8:3]}); endfunction

  assign mm_rdata = mmem[mi(mm_addr)];
  assign ax_rdata = amem[ai(ax_addr)];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mm_wr) mmem[mi(mm_addr)] <= mm_wdata;
    if (ax_wr) amem[ai(ax_addr)] <= ax_wdata;
    acc <= acc + int'(mm_rd) + int'(mm_wr) + int'(ax_rd) + int'(ax_wr);
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fill();
    for (int i = 0; i < 64; i++) mmem[i] = {$urandom, $urandom};
    for (int i = 0; i < 128; i++) amem[i] = {$urandom, $urandom};
    for (int i = 0; i < 64; i++) emm[i] = mmem[i];
    for (int i = 0; i < 128; i++) eam[i] = amem[i];
  endtask

  task automatic run(logic [25:0] ma, logic [25:0] aa, int n, bit d,
                     logic [6:0] inf, bit poke);
    int exp_acc = 0, t0, t1, a0;
    logic [15:0] v;
    bit same;
    fill();
    for (int k = 0; k < n / 8; k++) begin
      logic [25:0] m = ma + 26'(8 * k);
      logic [25:0] x = aa + 26'(8 * k);
      if ({1'b0, x} < AUX_SIZE) begin
        exp_acc += 2;
        if (!d) begin
          eam[ai(x)] = emm[mi(m)];
          if (inf[3:0] == 4'd4 && x < 26'h400000 &&
              ({1'b0, x} + 27'h400000) < AUX_SIZE) begin
            eam[ai(x + 26'h400000)] = emm[mi(m)];
            exp_acc += 1;
          end
        end else emm[mi(m)] = eam[ai(x)];
      end
    end
    wr(4'd6, {9'd0, inf});
    wr(4'd0, {6'd0, ma[25:16]});
    wr(4'd1, ma[15:0]);
    wr(4'd2, {6'd0, aa[25:16]});
    wr(4'd3, aa[15:0]);
    wr(4'd4, {d, 5'd0, 10'(n >> 16)});
    @(negedge clk); a0 = acc;
    reg_we = 1'b1; reg_addr = 4'd5; reg_wdata = 16'(n);
    @(posedge clk);
    #1 reg_we = 1'b0; t0 = cyc;
    rd(4'd8, v);
    chk(v[0] == 1'b1, "R3 busy after start", v, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      wr(4'd4, {~d, 5'd0, 10'd0});
      wr(4'd5, 16'h0100);
      wr(4'd1, 16'h1240);
    end
    forever begin
      rd(4'd8, v);
      if (!v[0]) break;
    end
    t1 = cyc;
    chk(t1 - t0 == (n / 32) * COST + 1, "R6 busy length", t1 - t0, (n / 32) * COST + 1);
    chk(v[1] == 1'b1 && irq == 1'b1, "R6 irq at completion", {v[1], irq}, 3);
    same = 1;
    for (int i = 0; i < 64; i++) if (mmem[i] !== emm[i]) same = 0;
    for (int i = 0; i < 128; i++) if (amem[i] !== eam[i]) same = 0;
    chk(same, "R4 R8 R9 memory contents", same, 1);
    chk(acc - a0 == exp_acc, "R9 R8 port access count", acc - a0, exp_acc);
    rd(4'd1, v);
    chk(v == 16'(ma + 26'(n)), "R5 main low after", v, 16'(ma + 26'(n)));
    rd(4'd0, v);
    chk(v == {6'd0, 10'((ma + 26'(n)) >> 16)}, "R5 main high after", v, 10'((ma + 26'(n)) >> 16));
    rd(4'd3, v);
    chk(v == 16'(aa + 26'(n)), "R5 aux low after", v, 16'(aa + 26'(n)));
    rd(4'd5, v);
    chk(v == 16'd0, "R5 R10 count low after", v, 0);
    rd(4'd4, v);
    chk(v == {d, 15'd0}, "R10 direction kept", v, {d, 15'd0});
    wr(4'd8, 16'h0002);
    rd(4'd8, v);
    chk(v == 16'd0 && irq == 1'b0, "R7 irq cleared", v, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      done_flag = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(4'd8, v); chk(v == 16'd0 && irq == 1'b0, "R3 R7 reset status", v, 0);
    rd(4'd7, v); chk(v == 16'h0001, "R2 mode at reset", v, 1);
    rd(4'd1, v); chk(v == 16'd0, "R1 main low reset", v, 0);

    wr(4'd0, 16'hFFFF); rd(4'd0, v); chk(v == 16'h03FF, "R1 main high mask", v, 16'h03FF);
    wr(4'd1, 16'hFFFF); rd(4'd1, v); chk(v == 16'hFFE0, "R1 main low mask", v, 16'hFFE0);
    wr(4'd2, 16'hFFFF); rd(4'd2, v); chk(v == 16'h03FF, "R1 aux high mask", v, 16'h03FF);
    wr(4'd3, 16'hFFFF); rd(4'd3, v); chk(v == 16'hFFE0, "R1 aux low mask", v, 16'hFFE0);
    wr(4'd4, 16'hFFFF); rd(4'd4, v); chk(v == 16'h83FF, "R1 count high mask", v, 16'h83FF);
    wr(4'd6, 16'hFFFF); rd(4'd6, v); chk(v == 16'h007F, "R1 info mask", v, 16'h007F);
    wr(4'd7, 16'h0000); rd(4'd7, v); chk(v == 16'h0001, "R2 mode write ignored", v, 1);
    wr(4'd4, 16'h0000);

    // R5 wrap past 64 MB
    run(26'h3FFFFE0, 26'h0000100, 64, 1'b0, 7'd0, 1'b0);
    // R6 zero count
    run(26'h0000040, 26'h0000040, 0, 1'b0, 7'd0, 1'b0);
    // R8 doubling across the 4 MB limit
    run(26'h0000000, 26'h03FFFE0, 64, 1'b0, 7'd4, 1'b0);
    // R8 no doubling in the other direction
    run(26'h0000080, 26'h0000020, 64, 1'b1, 7'd4, 1'b0);
    // R9 out-of-range tail
    run(26'h0000100, 26'h07FFFE0, 64, 1'b0, 7'd0, 1'b0);
    run(26'h0000100, 26'h07FFFE0, 64, 1'b1, 7'd0, 1'b0);
    // R10 restart attempt while busy
    run(26'h0000000, 26'h0000100, 64, 1'b0, 7'd0, 1'b1);

    for (int t = 0; t < 14; t++) begin
      logic [25:0] ma, aa;
      int n, sel;
      logic [6:0] inf;
      n = 32 * (1 + int'($urandom_range(0, 3)));
      ma = {$urandom} & 26'h3FFFFE0;
      sel = int'($urandom_range(0, 2));
      case (sel)
        0: aa = 26'h0000000 + 26'(32 * $urandom_range(0, 7));
        1: aa = 26'h03FFF80 + 26'(32 * $urandom_range(0, 3));
        default: aa = 26'h07FFF80 + 26'(32 * $urandom_range(0, 5));
      endcase
      case ($urandom_range(0, 2))
        0: inf = 7'd0;
        1: inf = 7'd3;
        default: inf = 7'd4;
      endcase
      run(ma, aa, n, 1'($urandom_range(0, 1)), inf, 1'b0);
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule